// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block holds the byte-wide configuration of a display power controller in two copies. The working copy is volatile, drives the device and is the copy the register bus normally reaches. The backup copy is an internal array that stands in for non-volatile storage. Each register keeps only its implemented bits. At power-up a sequencer walks the backup array and fills the working copy from it. A store command walks the other way, copying the working copy into the backup array. While either walk runs, a busy flag is raised.

A control byte at the top of the address space does two jobs. One bit chooses whether reads return working or backup contents. A second, self-clearing bit starts a store. A write-protect enable bit in the first configuration register gates all bus traffic, reads and writes alike, on an external protect pin. A second address space, picked by a select input, holds a 7-bit common-voltage wiper, its non-volatile initial value, and a mode byte that sets which of the two a write reaches.

A simple strobe bus takes the place of a serial slave. The bus has an address, write data, write and read strobes, and read data registered one cycle after the read strobe. `rst_ni` models a power cycle of the volatile domain. `nv_init_ni` models factory programming of the backup contents.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After `rst_ni` releases, `busy_o` stays high for 22 cycles while every working register is loaded from its backup entry. With factory backup contents, address 00h reads 02h, 03h reads 0Fh and 10h reads 05h.
- R2: Bits a register does not implement ignore writes and read as 0. Address 01h keeps bits 1:0 and address 02h keeps bits 3:0.
- R3: Bit 0 of the control byte at FFh selects the read source: 0 gives working data and 1 gives backup data.
- R4: Writing FFh with bit 7 set raises `busy_o` from the next cycle. Every working register is then copied into the backup array. Control bit 7 reads 1 until the copy ends and 0 afterwards.
- R5: While a store runs, write strobes have no effect.
- R6: Bit 7 of address 00h is volatile. It is never written into the backup array and reads 0 after every power-up.
- R7: When bit 2 of address 00h is 1 and `wp_i` is high, reads return 00h and writes are ignored. With `wp_i` low, or with the bit at 0, the bus is active.
- R8: Once bit 2 of address 00h is set, writing 0 to it while `wp_i` is high has no effect. The same write with `wp_i` low clears it.
- R9: In the wiper space (`sel_wiper_i`=1), when mode (address 02h) is 00h, a write to address 00h updates both the wiper and its initial value, and a read of 00h returns the initial value.
- R10: With mode 80h, writes and reads of wiper address 00h touch only the wiper. The initial value keeps its contents.
- R11: At power-up the wiper is loaded from its initial value and the mode resets to 00h. A mode write other than 00h or 80h is ignored.
- R12: Configuration addresses from 16h to FEh read 00h, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset of the volatile state |
| nv_init_ni | input | 1 | Active-low asynchronous factory initialisation of the backup contents |
| wp_i | input | 1 | Write-protect pin, active high |
| sel_wiper_i | input | 1 | 1 selects the wiper address space |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Read data, registered on the read strobe edge |
| busy_o | output | 1 | Load or store walk in progress |
| wiper_o | output | 7 | Current wiper value |

## Verification
The hardest situations to reach are the ones that depend on what the backup array holds after a power cycle: a stored value coming back, and the volatile disable bit not coming back. The stimulus sets up distinct working values, issues a store, and pulses only `rst_ni` while the backup array is kept. It then reads both sources. A second hard case is a write that lands inside the store window. That write is sent on the cycle right after the store command, and its absence is checked once `busy_o` falls. The sticky protect enable is exercised by attempting to clear it with the pin high, then with the pin low.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
  localparam int unsigned NUM_REGS      = 22;
  localparam logic [7:0]  CTRL_ADDR     = 8'hFF;
  localparam int unsigned CFG_WPEN_BIT  = 2;
  localparam logic [7:0]  VOLATILE_MASK = 8'h80;  // bits of reg 0 never stored

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_LOAD, SEQ_STORE} seq_state_e;

  function automatic logic [7:0] reg_mask(int unsigned idx);
    case (idx)
      0:                    return 8'h8F;
      1, 4, 12, 14:         return 8'h03;
      3:                    return 8'h1F;
      8, 9, 11, 13, 15,
      17, 18:               return 8'h07;
      21:                   return 8'hFF;
      default:              return 8'h0F;
    endcase
  endfunction

  function automatic logic [7:0] reg_default(int unsigned idx);
    case (idx)
      0, 2, 6, 13, 18:      return 8'h02;
      1, 14:                return 8'h03;
      3:                    return 8'h0F;
      4, 8, 9, 11, 12:      return 8'h01;
      5, 10:                return 8'h04;
      7:                    return 8'h09;
      15, 19, 20:           return 8'h07;
      16:                   return 8'h05;
      default:              return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_shadow_pkg::*;
#(
  parameter int unsigned N    = NUM_REGS,
  localparam int unsigned IW  = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          store_req_i,
  output logic          busy_o,
  output logic          loading_o,
  output logic          storing_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  seq_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_LOAD;
      idx_o   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (store_req_i) state_q <= SEQ_STORE;
        default: begin
          if (idx_o == LAST) begin
            state_q <= SEQ_IDLE;
            idx_o   <= '0;
          end else begin
            idx_o <= idx_o + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o    = (state_q != SEQ_IDLE);
  assign loading_o = (state_q == SEQ_LOAD);
  assign storing_o = (state_q == SEQ_STORE);

  // R4
  store_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_i && !busy_o |=> storing_o);
endmodule

// File: rtl/cfg_wiper.sv
module cfg_wiper #(
  parameter int unsigned WW         = 7,
  parameter logic [WW-1:0] IV_RESET = WW'(8'h40)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          nv_init_ni,
  input  logic          load_i,
  input  logic          wr_i,
  input  logic [7:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic [WW-1:0] wiper_o
);
  localparam logic [7:0] MODE_BOTH  = 8'h00;
  localparam logic [7:0] MODE_WIPER = 8'h80;

  logic [WW-1:0] iv_q;
  logic [7:0]    mode_q;
  logic          wr_val, wr_mode;

  assign wr_val  = wr_i && (addr_i == 8'h00);
  assign wr_mode = wr_i && (addr_i == 8'h02) &&
                   (wdata_i == MODE_BOTH || wdata_i == MODE_WIPER);

  always_ff @(posedge clk_i or negedge nv_init_ni) begin
    if (!nv_init_ni)                          iv_q <= IV_RESET;
    else if (wr_val && mode_q == MODE_BOTH)   iv_q <= wdata_i[WW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_o <= '0;
      mode_q  <= MODE_BOTH;
    end else begin
      if (load_i)       wiper_o <= iv_q;
      else if (wr_val)  wiper_o <= wdata_i[WW-1:0];
      if (wr_mode)      mode_q  <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == 8'h00)
      rdata_o = 8'((mode_q == MODE_BOTH) ? iv_q : wiper_o);
    else if (addr_i == 8'h02)
      rdata_o = mode_q;
  end

  // R10
  mode80_iv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !nv_init_ni)
    mode_q == MODE_WIPER && wr_i |=> $stable(iv_q));
  // R11
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_BOTH || mode_q == MODE_WIPER);
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
  import cfg_shadow_pkg::*;
#(
  parameter int unsigned N  = NUM_REGS,
  parameter int unsigned WW = 7,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          nv_init_ni,
  input  logic          wp_i,
  input  logic          sel_wiper_i,
  input  logic [7:0]    addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [7:0]    rd_data_o,
  output logic          busy_o,
  output logic [WW-1:0] wiper_o
);
  logic [N-1:0][7:0] work_q, nv_q;
  logic [IW-1:0]     idx;
  logic              loading, storing, src_nv_q;
  logic              bus_ok, wr_ok, ctrl_wr, store_req;
  logic [7:0]        cfg_rdata, wip_rdata;

  // protect gate: enable bit lives in working reg 0
  assign bus_ok    = !work_q[0][CFG_WPEN_BIT] || !wp_i;
  assign wr_ok     = wr_i && bus_ok && !busy_o;
  assign ctrl_wr   = wr_ok && !sel_wiper_i && (addr_i == CTRL_ADDR);
  assign store_req = ctrl_wr && wdata_i[7];

  cfg_seq #(.N(N)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .store_req_i(store_req),
    .busy_o     (busy_o),
    .loading_o  (loading),
    .storing_o  (storing),
    .idx_o      (idx)
  );

  for (genvar i = 0; i < N; i++) begin : g_reg
    localparam logic [7:0] MASK    = reg_mask(i);
    localparam logic [7:0] NV_MASK = (i == 0) ? (MASK & ~VOLATILE_MASK) : MASK;
    localparam logic [7:0] DEF     = reg_default(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        work_q[i] <= '0;
      else if (loading && idx == IW'(i))
        work_q[i] <= nv_q[i] & NV_MASK;
      else if (wr_ok && !sel_wiper_i && addr_i == 8'(i))
        work_q[i] <= wdata_i & MASK;
    end

    always_ff @(posedge clk_i or negedge nv_init_ni) begin
      if (!nv_init_ni)
        nv_q[i] <= DEF & NV_MASK;
      else if (storing && idx == IW'(i))
        nv_q[i] <= work_q[i] & NV_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      src_nv_q <= 1'b0;
    else if (ctrl_wr) src_nv_q <= wdata_i[0];
  end

  always_comb begin
    cfg_rdata = 8'h00;
    if (addr_i == CTRL_ADDR)
      cfg_rdata = {storing, 6'b0, src_nv_q};
    for (int i = 0; i < N; i++)
      if (addr_i == 8'(i)) cfg_rdata = src_nv_q ? nv_q[i] : work_q[i];
  end

  cfg_wiper #(.WW(WW)) i_wiper (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nv_init_ni(nv_init_ni),
    .load_i    (loading && idx == '0),
    .wr_i      (wr_ok && sel_wiper_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (wip_rdata),
    .wiper_o   (wiper_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_o <= 8'h00;
    else if (rd_i) rd_data_o <= !bus_ok ? 8'h00 : (sel_wiper_i ? wip_rdata : cfg_rdata);
  end

  // R5
  busy_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    storing && wr_i |=> $stable(work_q));
  // R7
  wp_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    work_q[0][CFG_WPEN_BIT] && wp_i && rd_i |=> rd_data_o == 8'h00);
  // R6
  nv_volatile_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !nv_init_ni)
    (nv_q[0] & VOLATILE_MASK) == 8'h00);
  // R12
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !sel_wiper_i && !busy_o && addr_i >= 8'(N) && addr_i != CTRL_ADDR
    |=> $stable(work_q));
endmodule

// File: tb/test_cfg_shadow_bank.sv
`timescale 1ns/1ps
module test_cfg_shadow_bank;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0, nv_init_ni = 1'b0, wp_i = 1'b0, sel = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rd_data;
  logic       busy;
  logic [6:0] wiper;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  cfg_shadow_bank i_cfg_shadow_bank (
    .clk_i(clk), .rst_ni(rst_ni), .nv_init_ni(nv_init_ni), .wp_i(wp_i),
    .sel_wiper_i(sel), .addr_i(addr), .wdata_i(wdata), .wr_i(wr_i), .rd_i(rd_i),
    .rd_data_o(rd_data), .busy_o(busy), .wiper_o(wiper)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic sw, logic [7:0] a, logic [7:0] d);
    @(negedge clk); sel = sw; addr = a; wdata = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic rd(logic sw, logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk); sel = sw; addr = a; rd_i = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic power_up(logic factory);
    int n;
    @(negedge clk); rst_ni = 1'b0; if (factory) nv_init_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1; nv_init_ni = 1'b1;
    n = 0;
    while (busy) begin @(negedge clk); n++; end
    check("R1 load length", 8'(n), 8'd22);
  endtask

  // monitor: pops one expected item per read strobe
  initial forever begin
    @(posedge clk);
    if (rd_i) begin
      @(negedge clk);
      check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    power_up(1'b1);
    rd(0, 8'h00, 8'h02, "R1 reg00 default");
    rd(0, 8'h03, 8'h0F, "R1 reg03 default");
    rd(0, 8'h10, 8'h05, "R1 reg10 default");
    rd(1, 8'h02, 8'h00, "R11 mode reset");
    check("R11 wiper from iv", 8'(wiper), 8'h40);

    wr(0, 8'h01, 8'hFF); rd(0, 8'h01, 8'h03, "R2 reg01 mask");
    wr(0, 8'h02, 8'hFF); rd(0, 8'h02, 8'h0F, "R2 reg02 mask");

    wr(0, 8'h30, 8'hAA); rd(0, 8'h30, 8'h00, "R12 unmapped read");
    rd(0, 8'h16, 8'h00, "R12 first unmapped");
    rd(0, 8'h01, 8'h03, "R12 no side effect");

    wr(0, 8'h00, 8'h8A); rd(0, 8'h00, 8'h8A, "R6 volatile bit writable");
    wr(0, 8'h03, 8'h12);
    wr(0, 8'hFF, 8'h80);
    check("R4 busy after store", 8'(busy), 8'h01);
    wr(0, 8'h03, 8'h05);                      // R5 lands inside store window
    rd(0, 8'hFF, 8'h80, "R4 store bit while busy");
    while (busy) @(negedge clk);
    rd(0, 8'hFF, 8'h00, "R4 store bit self clear");
    rd(0, 8'h03, 8'h12, "R5 write during store ignored");
    wr(0, 8'hFF, 8'h01);
    rd(0, 8'h03, 8'h12, "R3 backup source");
    rd(0, 8'h00, 8'h0A, "R6 volatile bit not stored");
    wr(0, 8'h03, 8'h07);                      // ctrl not busy: working only
    rd(0, 8'h03, 8'h12, "R3 backup unchanged by working write");
    wr(0, 8'hFF, 8'h00);
    rd(0, 8'h03, 8'h07, "R3 working source");

    power_up(1'b0);
    rd(0, 8'h03, 8'h12, "R1 stored value reloaded");
    rd(0, 8'h00, 8'h0A, "R6 volatile bit clear after power-up");

    wr(0, 8'h00, 8'h04);
    @(negedge clk); wp_i = 1'b1;
    rd(0, 8'h03, 8'h00, "R7 protected read");
    wr(0, 8'h03, 8'h1F);
    wr(0, 8'h00, 8'h00);
    @(negedge clk); wp_i = 1'b0;
    rd(0, 8'h03, 8'h12, "R7 protected write ignored");
    rd(0, 8'h00, 8'h04, "R8 enable kept with pin high");
    wr(0, 8'h00, 8'h00);
    @(negedge clk); wp_i = 1'b1;
    rd(0, 8'h03, 8'h12, "R8 cleared with pin low");

    wr(1, 8'h00, 8'h25);
    check("R9 wiper written", 8'(wiper), 8'h25);
    rd(1, 8'h00, 8'h25, "R9 read initial value");
    wr(1, 8'h02, 8'h80);
    wr(1, 8'h00, 8'h33);
    check("R10 wiper only", 8'(wiper), 8'h33);
    rd(1, 8'h00, 8'h33, "R10 read wiper");
    wr(1, 8'h02, 8'h00);
    rd(1, 8'h00, 8'h25, "R10 initial value kept");
    wr(1, 8'h02, 8'h41);
    rd(1, 8'h02, 8'h00, "R11 illegal mode ignored");
    wr(1, 8'h02, 8'h80);
    wr(1, 8'h00, 8'h11);
    power_up(1'b0);
    check("R11 wiper reloaded", 8'(wiper), 8'h25);
    rd(1, 8'h02, 8'h00, "R11 mode after power-up");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule